// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block recovers frames from a single asynchronous serial line using only the system clock. Software-free configuration inputs select the bit period in clock cycles, the number of data bits (5 to 9), the parity scheme, whether the first data bit is the least or most significant, and whether the line idles low instead of high. The line passes through a two-stage synchronizer. An edge from the idle level opens a frame. Every bit slot is then sampled once, near its middle.

Each frame ends in exactly one result: a one-cycle `frame_done` pulse with the assembled word and a single `frame_valid` flag. Three error pulses travel with that result and say why a frame was rejected. A start bit that is no longer active at its sample point ends the frame early. A wrong parity bit or a missing stop bit still lets the frame run to its end, so that the data is delivered. Configuration must only change while the line is idle.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, `frame_done`, `frame_valid`, `start_err`, `parity_err` and `stop_err` are 0 and `data` is 0.
- R2: In idle, a transition of the line from its idle level to the active level opens a frame. The result for a frame whose stop bit sits in slot S appears 3 + floor(P/2) + S·P clock cycles after the line change, where P = `cfg_clks_per_bit`. Slot 0 is the start bit, slots 1..N are data, then the parity slot if parity is used, then the stop slot.
- R3: Slot n is sampled floor(P/2) + n·P clock cycles after the first synchronized sample of the frame, for any P of at least 4.
- R4: When the start bit reads 1 at its sample point, `frame_done` pulses 3 + floor(P/2) cycles after the line change, with `start_err`=1, `frame_valid`=0, `data`=0 and `parity_err`=`stop_err`=0. The receiver then returns to idle.
- R5: `cfg_data_bits` (5..9) sets N, the number of data bits. Bits of `data` at position N and above read 0.
- R6: With `cfg_msb_first`=0, the first data bit received lands in `data[0]`. With `cfg_msb_first`=1, the first data bit received lands in `data[N-1]`.
- R7: `cfg_parity` encodes 0 = none (no parity slot), 1 = odd, 2 = even, 3 = forced 0, 4 = forced 1. For odd and even, the number of ones across the data bits and the parity bit must be odd or even respectively.
- R8: A parity bit that breaks the rule of R7 gives `parity_err`=1 and `frame_valid`=0 in the result. The stop slot is still sampled, and `data` still carries the word.
- R9: With `cfg_parity_check`=0, a wrong parity bit gives `parity_err`=0 and leaves `frame_valid` unaffected. The parity slot still takes one bit time, so the latency of R2 still counts it.
- R10: A stop bit that reads 0 gives `stop_err`=1 and `frame_valid`=0, while `data` still carries the received word.
- R11: With `cfg_invert`=1, the line idles low, a rising edge opens a frame, and every sampled bit is inverted before it is used.
- R12: `frame_done` lasts one cycle. The error pulses are only high together with it. `frame_valid` is 1 exactly when none of the three errors is set. `data` changes only with `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Asynchronous serial line |
| cfg_clks_per_bit | input | 16 | Bit period in clock cycles, at least 4 |
| cfg_data_bits | input | 4 | Data bits per frame, 5 to 9 |
| cfg_parity | input | 3 | Parity scheme: 0 none, 1 odd, 2 even, 3 forced 0, 4 forced 1 |
| cfg_parity_check | input | 1 | 1 = report parity mismatches |
| cfg_msb_first | input | 1 | 1 = first data bit is the most significant |
| cfg_invert | input | 1 | 1 = line idles low and bits are inverted |
| frame_done | output | 1 | One-cycle pulse: a frame result is present |
| data | output | 9 | Assembled data word, held until the next result |
| frame_valid | output | 1 | Result carries no error, held until the next result |
| start_err | output | 1 | Pulse: start bit was not active at its sample point |
| parity_err | output | 1 | Pulse: parity bit mismatch |
| stop_err | output | 1 | Pulse: stop bit read 0 |

## Verification
Every result has a fixed due cycle. It falls 3 + floor(P/2) + S·P clocks after the line first leaves idle: two clocks for the synchronizer, one for the edge register, and S·P for the slots that follow the half-bit offset. A false start is due at S = 0. The driver logs the cycle on which it changes the line, computes the due cycle and the expected fields, and queues them. The monitor samples on the falling clock edge and checks each result against the head of the queue, the arrival cycle included. A result that comes early, late or unexpected is reported.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int MAX_DATA_BITS = 9;
    localparam int CPB_W         = 16;
    localparam int SYNC_STAGES   = 2;
    localparam int BIT_IDX_W     = $clog2(MAX_DATA_BITS + 1);

    typedef enum logic [2:0] {
        PAR_NONE = 3'd0,
        PAR_ODD  = 3'd1,
        PAR_EVEN = 3'd2,
        PAR_ZERO = 3'd3,
        PAR_ONE  = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        rx_state_e                state;
        logic [BIT_IDX_W-1:0]     idx;
        logic [MAX_DATA_BITS-1:0] word;
        logic                     par_acc;
        logic                     par_bad;
        logic                     done;
        logic [MAX_DATA_BITS-1:0] data;
        logic                     valid;
        logic                     se;
        logic                     pe;
        logic                     te;
    } rx_regs_t;

endpackage

// File: rtl/rx_line_front.sv
module rx_line_front
    import uart_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic invert,
    output logic level,
    output logic start_seen
);
    logic [SYNC_STAGES-1:0] sync_q, sync_d;
    logic                   prev_q, prev_d;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], line_in};
        prev_d = sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    logic prev_lvl;
    always_comb begin
        level      = sync_q[SYNC_STAGES-1] ^ invert;
        prev_lvl   = prev_q ^ invert;
        start_seen = prev_lvl & ~level;
    end
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
    import uart_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             active,
    input  logic [CPB_W-1:0] cpb,
    output logic             tick
);
    logic [CPB_W-1:0] cnt_q, cnt_d;

    always_comb begin
        tick  = active && (cnt_q == '0);
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = (cpb >> 1) - 1'b1;
        end else if (active) begin
            if (cnt_q == '0) cnt_d = cpb - 1'b1;
            else             cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rx_parity_judge.sv
module rx_parity_judge
    import uart_rx_pkg::*;
(
    input  par_mode_e mode,
    input  logic      data_xor,
    input  logic      par_bit,
    output logic      par_ok
);
    always_comb begin
        unique case (mode)
            PAR_ODD:  par_ok = data_xor ^ par_bit;
            PAR_EVEN: par_ok = ~(data_xor ^ par_bit);
            PAR_ZERO: par_ok = ~par_bit;
            PAR_ONE:  par_ok = par_bit;
            default:  par_ok = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_rx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rxd,
    input  logic [CPB_W-1:0]         cfg_clks_per_bit,
    input  logic [BIT_IDX_W-1:0]     cfg_data_bits,
    input  logic [2:0]               cfg_parity,
    input  logic                     cfg_parity_check,
    input  logic                     cfg_msb_first,
    input  logic                     cfg_invert,
    output logic                     frame_done,
    output logic [MAX_DATA_BITS-1:0] data,
    output logic                     frame_valid,
    output logic                     start_err,
    output logic                     parity_err,
    output logic                     stop_err
);
    rx_regs_t r_q, r_d;

    logic lvl, start_seen, tick, par_ok;
    logic [BIT_IDX_W-1:0] last_idx, pos;
    par_mode_e mode;

    assign mode = par_mode_e'(cfg_parity);

    rx_line_front u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (rxd),
        .invert     (cfg_invert),
        .level      (lvl),
        .start_seen (start_seen)
    );

    rx_bit_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (r_q.state == ST_IDLE && start_seen),
        .active  (r_q.state != ST_IDLE),
        .cpb     (cfg_clks_per_bit),
        .tick    (tick)
    );

    rx_parity_judge u_par (
        .mode     (mode),
        .data_xor (r_q.par_acc),
        .par_bit  (lvl),
        .par_ok   (par_ok)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.se   = 1'b0;
        r_d.pe   = 1'b0;
        r_d.te   = 1'b0;
        last_idx = cfg_data_bits - 1'b1;
        pos      = cfg_msb_first ? (last_idx - r_q.idx) : r_q.idx;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_seen) begin
                    r_d.state   = ST_START;
                    r_d.idx     = '0;
                    r_d.word    = '0;
                    r_d.par_acc = 1'b0;
                    r_d.par_bad = 1'b0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (lvl) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.se    = 1'b1;
                        r_d.valid = 1'b0;
                        r_d.data  = '0;
                    end else begin
                        r_d.state = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    r_d.word[pos] = lvl;
                    r_d.par_acc   = r_q.par_acc ^ lvl;
                    r_d.idx       = r_q.idx + 1'b1;
                    if (r_q.idx == last_idx)
                        r_d.state = (mode == PAR_NONE) ? ST_STOP : ST_PARITY;
                end
            end
            ST_PARITY: begin
                if (tick) begin
                    r_d.par_bad = cfg_parity_check && !par_ok;
                    r_d.state   = ST_STOP;
                end
            end
            ST_STOP: begin
                if (tick) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.data  = r_q.word;
                    r_d.valid = lvl && !r_q.par_bad;
                    r_d.pe    = r_q.par_bad;
                    r_d.te    = !lvl;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign frame_done  = r_q.done;
    assign data        = r_q.data;
    assign frame_valid = r_q.valid;
    assign start_err   = r_q.se;
    assign parity_err  = r_q.pe;
    assign stop_err    = r_q.te;
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk
    import uart_rx_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic [2:0]               cfg_parity,
    input logic                     cfg_parity_check,
    input logic                     frame_done,
    input logic [MAX_DATA_BITS-1:0] data,
    input logic                     frame_valid,
    input logic                     start_err,
    input logic                     parity_err,
    input logic                     stop_err
);
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_err_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (start_err || parity_err || stop_err) |-> frame_done);

    assert_valid_agg_R12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (frame_valid == !(start_err || parity_err || stop_err)));

    assert_data_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> $stable(data));

    assert_false_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_err |-> (!parity_err && !stop_err && data == '0));

    assert_no_check_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_parity_check || cfg_parity == 3'd0) |-> !parity_err);
endmodule

bind uart_frame_rx uart_frame_rx_chk u_chk (.*);

// File: tb/sim_uart_frame_rx.sv
module sim_uart_frame_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic [15:0] cfg_clks_per_bit = 16'd8;
    logic [3:0]  cfg_data_bits = 4'd8;
    logic [2:0]  cfg_parity = 3'd0;
    logic        cfg_parity_check = 1'b1;
    logic        cfg_msb_first = 1'b0;
    logic        cfg_invert = 1'b0;
    logic        frame_done;
    logic [8:0]  data;
    logic        frame_valid, start_err, parity_err, stop_err;

    uart_frame_rx u0 (.*);

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic [8:0] d;
        bit v, se, pe, te;
        int due;
        string req;
    } exp_t;
    exp_t sb[$];

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && frame_done) begin
            if (sb.size() == 0) begin
                check(0, "R12", "unexpected frame_done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cyc == e.due, e.req, "result cycle", cyc, e.due);
                check(data == e.d, e.req, "data", int'(data), int'(e.d));
                check(frame_valid == e.v, e.req, "frame_valid", int'(frame_valid), int'(e.v));
                check(start_err == e.se, e.req, "start_err", int'(start_err), int'(e.se));
                check(parity_err == e.pe, e.req, "parity_err", int'(parity_err), int'(e.pe));
                check(stop_err == e.te, e.req, "stop_err", int'(stop_err), int'(e.te));
            end
        end
    end

    task automatic configure(int cpb, int nb, int pm, bit chk, bit msb, bit inv);
        @(posedge clk); #1;
        cfg_clks_per_bit = 16'(cpb);
        cfg_data_bits    = 4'(nb);
        cfg_parity       = 3'(pm);
        cfg_parity_check = chk;
        cfg_msb_first    = msb;
        cfg_invert       = inv;
        rxd              = ~inv;
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic hold_bit(bit b);
        rxd = b ^ cfg_invert;
        repeat (int'(cfg_clks_per_bit)) @(posedge clk);
        #1;
    endtask

    task automatic send_frame(logic [8:0] v, bit flip, bit stopv, string req);
        int   p, nb, pm, s;
        bit   pb;
        exp_t e;
        logic [8:0] m;
        p  = int'(cfg_clks_per_bit);
        nb = int'(cfg_data_bits);
        pm = int'(cfg_parity);
        m  = v & 9'((1 << nb) - 1);
        pb = 1'b0;
        for (int i = 0; i < nb; i++) pb ^= m[i];
        case (pm)
            1: pb = ~pb;
            2: pb = pb;
            3: pb = 1'b0;
            4: pb = 1'b1;
            default: pb = 1'b0;
        endcase
        pb ^= flip;
        s = 1 + nb + ((pm != 0) ? 1 : 0);
        @(posedge clk); #1;
        e.d   = m;
        e.pe  = flip && (pm != 0) && cfg_parity_check;
        e.te  = !stopv;
        e.se  = 0;
        e.v   = !e.pe && stopv;
        e.due = cyc + 3 + p / 2 + s * p;
        e.req = req;
        sb.push_back(e);
        hold_bit(1'b0);
        for (int i = 0; i < nb; i++)
            hold_bit(cfg_msb_first ? m[nb-1-i] : m[i]);
        if (pm != 0) hold_bit(pb);
        hold_bit(stopv);
        rxd = ~cfg_invert;
        repeat (3 * p) @(posedge clk);
        #1;
    endtask

    task automatic glitch(string req);
        int p;
        exp_t e;
        p = int'(cfg_clks_per_bit);
        @(posedge clk); #1;
        e.d = 9'd0; e.v = 0; e.se = 1; e.pe = 0; e.te = 0;
        e.due = cyc + 3 + p / 2;
        e.req = req;
        sb.push_back(e);
        rxd = cfg_invert;
        @(posedge clk); #1;
        rxd = ~cfg_invert;
        repeat (3 * p) @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(frame_done == 0 && frame_valid == 0 && start_err == 0 &&
              parity_err == 0 && stop_err == 0, "R1", "flags", 0, 0);
        check(data == 9'd0, "R1", "data", int'(data), 0);

        // R2 R5: 8 bits, no parity, lsb first
        configure(8, 8, 0, 1, 0, 0);
        send_frame(9'h0A5, 0, 1, "R2");
        send_frame(9'h13C, 0, 1, "R5");
        // R5 R7: 5 bits odd parity
        configure(8, 5, 1, 1, 0, 0);
        send_frame(9'h013, 0, 1, "R7");
        send_frame(9'h1F6, 0, 1, "R5");
        // R6: 9 bits even parity msb first, and lsb first with same value
        configure(8, 9, 2, 1, 1, 0);
        send_frame(9'h1A6, 0, 1, "R6");
        configure(8, 9, 2, 1, 0, 0);
        send_frame(9'h1A6, 0, 1, "R6");
        // R7 R8: forced zero, then wrong parity
        configure(8, 7, 3, 1, 0, 0);
        send_frame(9'h055, 0, 1, "R7");
        send_frame(9'h055, 1, 1, "R8");
        configure(8, 8, 2, 1, 0, 0);
        send_frame(9'h0C3, 1, 1, "R8");
        // R9: forced one, wrong parity ignored
        configure(8, 8, 4, 0, 0, 0);
        send_frame(9'h0E1, 1, 1, "R9");
        configure(8, 6, 1, 0, 0, 0);
        send_frame(9'h02D, 1, 1, "R9");
        // R10: stop error, and stop plus parity error
        configure(8, 8, 2, 1, 0, 0);
        send_frame(9'h09A, 0, 0, "R10");
        send_frame(9'h07E, 1, 0, "R10");
        // R11: inverted line, 6 bits odd, P=5
        configure(5, 6, 1, 1, 0, 1);
        send_frame(9'h02B, 0, 1, "R11");
        send_frame(9'h011, 1, 1, "R11");
        glitch("R11");
        // R3: minimum bit period, msb first
        configure(4, 8, 0, 1, 1, 0);
        send_frame(9'h0B4, 0, 1, "R3");
        configure(13, 8, 2, 1, 0, 0);
        send_frame(9'h0F0, 0, 1, "R3");
        // R4: false start bit
        configure(8, 8, 0, 1, 0, 0);
        glitch("R4");
        send_frame(9'h05A, 0, 1, "R4");

        repeat (40) @(posedge clk);
        @(negedge clk);
        check(sb.size() == 0, "R12", "pending results", sb.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule